// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits at the issue stage of an out-of-order core. Instructions reach it already ready to run. Each carries a sequence number, an operation class and an opaque tag. Every class has its own ready pool, and each pool feeds the one function unit that serves that class. Each clock the selector picks up to `ISSUE_W` instructions, oldest first across all classes. It sends out the tag, class and sequence number of each one on a numbered issue slot.

The block does not compare every stored entry on every cycle. Each pool is kept sorted, so its oldest entry is always at the front. A small age matrix records how the front entries of the classes are ordered. When a pool's front entry changes, because it issued, was overtaken by an older insert, or the pool filled or emptied, only the matrix rows and columns of that class are rewritten. The pick network therefore reads only stored order bits, eligibility and function-unit availability.

A squash input carries an upper sequence bound. Every entry younger than the bound is removed from all pools in that cycle. An error pulse reports an insertion into a pool that was already full.

Top module: `issel_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `iss_valid` is all zeros, `has_ready` is 0 and `ins_err` is 0.
- R2: An inserted instruction goes to the pool chosen by `ins_class` (0 to 3). When it issues, `iss_class` carries that same class, with its own tag and sequence number.
- R3: Within one class, the entry with the smallest sequence number issues first, whatever order the entries arrived in.
- R4: At most `ISSUE_W` (2) instructions issue per cycle, at most one per class. Slot 0 carries the oldest eligible class head and slot 1 the next-oldest, so when both slots are valid `iss_seq[0] < iss_seq[1]`. A valid slot 1 implies a valid slot 0.
- R5: A class whose `fu_free` bit is 0 issues nothing that cycle, and the walk goes on to the next-oldest class.
- R6: With `squash_valid` high, every entry whose sequence number is above `squash_bound` is removed from all pools at that clock edge and is not issued in that cycle. An insertion in the same cycle whose sequence number is above the bound is discarded.
- R7: `has_ready` is 1 exactly when at least one pool holds an entry, judged after the last clock edge.
- R8: An insertion that is not squashed, aimed at a pool that held 8 entries at the start of the cycle, is dropped. `ins_err` is 1 for the one cycle after that edge.
- R9: The issue outputs are registered. An instruction inserted at edge k can appear on an issue slot at edge k+1 at the earliest, and each issue is valid for exactly one cycle.
- R10: After a class head issues, that class competes with its next entry's sequence number. A younger head loses to older heads of other classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_seq | input | 16 | Sequence number of the inserted instruction |
| ins_class | input | 2 | Operation class of the inserted instruction |
| ins_tag | input | 8 | Opaque tag of the inserted instruction |
| fu_free | input | 4 | One bit per class: its function unit can accept an instruction |
| squash_valid | input | 1 | Squash request this cycle |
| squash_bound | input | 16 | Largest sequence number that survives a squash |
| iss_valid | output | 2 | Per issue slot: slot carries an instruction |
| iss_class | output | 2x2 | Per slot: class (function unit) of the issued instruction |
| iss_seq | output | 2x16 | Per slot: sequence number of the issued instruction |
| iss_tag | output | 2x8 | Per slot: tag of the issued instruction |
| has_ready | output | 1 | At least one pool is non-empty |
| ins_err | output | 1 | An insertion into a full pool was dropped last cycle |

## Verification
The hard overlap is a squash and a selection in the same cycle. The squash must win, so only heads at or below the bound may issue, while any survivors still issue in that same cycle. A directed case loads two classes with entries on both sides of a bound, then squashes with every function unit free and a doomed insertion pending. The behavioural queue model in the bench predicts that the two older heads issue and nothing remains. A random phase repeats this mix of squash, issue and insert alongside busy units and full pools, and compares every output each cycle.

// File: rtl/issel_pkg.sv
package issel_pkg;

    localparam int SEQ_W = 16;
    localparam int TAG_W = 8;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [TAG_W-1:0] tag_t;

    // strict age order between two class heads; equal numbers fall back to class index
    function automatic logic head_before(input seq_t a, input seq_t b, input int ia, input int ib);
        return (a < b) || ((a == b) && (ia < ib));
    endfunction

endpackage

// File: rtl/issel_pool.sv
module issel_pool
    import issel_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  seq_t push_seq,
    input  tag_t push_tag,
    input  logic pop,
    input  logic sq_valid,
    input  seq_t sq_bound,
    output seq_t head_seq,
    output tag_t head_tag,
    output logic nonempty,
    output logic reject,
    output seq_t nxt_head_seq,
    output logic head_chg
);

    seq_t            seq_q [DEPTH];
    tag_t            tag_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    seq_t            a_seq [DEPTH];
    tag_t            a_tag [DEPTH];
    seq_t            n_seq [DEPTH];
    tag_t            n_tag [DEPTH];
    logic [CNT_W-1:0] keep;
    logic [CNT_W-1:0] n1;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] nxt_cnt;
    logic            full;
    logic            doomed;
    logic            accept;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign doomed = sq_valid && (push_seq > sq_bound);
    assign accept = push && !full && !doomed;
    assign reject = push && full && !doomed;

    always_comb begin
        // entries are kept ascending, so squash survivors form a prefix
        keep = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < cnt_q) && (!sq_valid || (seq_q[i] <= sq_bound)))
                keep = keep + CNT_W'(1);
        end

        for (int i = 0; i < DEPTH - 1; i++) begin
            a_seq[i] = pop ? seq_q[i+1] : seq_q[i];
            a_tag[i] = pop ? tag_q[i+1] : tag_q[i];
        end
        a_seq[DEPTH-1] = seq_q[DEPTH-1];
        a_tag[DEPTH-1] = tag_q[DEPTH-1];

        n1 = (pop && (keep != '0)) ? keep - CNT_W'(1) : keep;

        pos = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if ((CNT_W'(j) < n1) && (a_seq[j] < push_seq))
                pos = pos + CNT_W'(1);
        end

        for (int i = 0; i < DEPTH; i++) begin
            if (!accept || (CNT_W'(i) < pos)) begin
                n_seq[i] = a_seq[i];
                n_tag[i] = a_tag[i];
            end else if (CNT_W'(i) == pos) begin
                n_seq[i] = push_seq;
                n_tag[i] = push_tag;
            end else begin
                n_seq[i] = a_seq[(i == 0) ? 0 : i - 1];
                n_tag[i] = a_tag[(i == 0) ? 0 : i - 1];
            end
        end

        nxt_cnt = accept ? n1 + CNT_W'(1) : n1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else begin
            cnt_q <= nxt_cnt;
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i] <= n_seq[i];
                tag_q[i] <= n_tag[i];
            end
        end
    end

    assign head_seq     = seq_q[0];
    assign head_tag     = tag_q[0];
    assign nonempty     = (cnt_q != '0);
    assign nxt_head_seq = n_seq[0];
    assign head_chg     = ((nxt_cnt != '0) != nonempty) || (n_seq[0] != seq_q[0]);

endmodule

// File: rtl/issel_age.sv
module issel_age
    import issel_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  seq_t         nxt_seq [N],
    input  logic [N-1:0] chg,
    output logic [N-1:0] older [N]
);

    logic [N-1:0] older_q [N];

    // only the rows and columns of a class whose head moved are re-placed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    older_q[i][j] <= (i < j);
        end else begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if ((i != j) && (chg[i] || chg[j]))
                        older_q[i][j] <= head_before(nxt_seq[i], nxt_seq[j], i, j);
        end
    end

    assign older = older_q;

endmodule

// File: rtl/issel_pick.sv
module issel_pick #(
    parameter int N = 4,
    parameter int W = 2,
    localparam int CLS_W = $clog2(N)
) (
    input  logic [N-1:0]            elig,
    input  logic [N-1:0]            older [N],
    output logic [W-1:0]            slot_v,
    output logic [W-1:0][CLS_W-1:0] slot_cls,
    output logic [N-1:0]            take
);

    logic [N-1:0] rem;
    logic         found;
    logic         win;

    always_comb begin
        rem      = elig;
        take     = '0;
        slot_v   = '0;
        slot_cls = '0;
        for (int s = 0; s < W; s++) begin
            found = 1'b0;
            for (int c = 0; c < N; c++) begin
                win = rem[c];
                for (int d = 0; d < N; d++) begin
                    if ((d != c) && rem[d] && !older[c][d])
                        win = 1'b0;
                end
                if (win && !found) begin
                    found       = 1'b1;
                    slot_v[s]   = 1'b1;
                    slot_cls[s] = CLS_W'(c);
                    take[c]     = 1'b1;
                end
            end
            rem = rem & ~take;
        end
    end

endmodule

// File: rtl/issel_top.sv
module issel_top
    import issel_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter int POOL_DEPTH  = 8,
    parameter int ISSUE_W     = 2,
    localparam int CLS_W = $clog2(NUM_CLASSES)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ins_valid,
    input  logic [issel_pkg::SEQ_W-1:0]            ins_seq,
    input  logic [CLS_W-1:0]                       ins_class,
    input  logic [issel_pkg::TAG_W-1:0]            ins_tag,
    input  logic [NUM_CLASSES-1:0]                 fu_free,
    input  logic                                   squash_valid,
    input  logic [issel_pkg::SEQ_W-1:0]            squash_bound,
    output logic [ISSUE_W-1:0]                     iss_valid,
    output logic [ISSUE_W-1:0][CLS_W-1:0]          iss_class,
    output logic [ISSUE_W-1:0][issel_pkg::SEQ_W-1:0] iss_seq,
    output logic [ISSUE_W-1:0][issel_pkg::TAG_W-1:0] iss_tag,
    output logic                                   has_ready,
    output logic                                   ins_err
);

    seq_t                         head_seq [NUM_CLASSES];
    tag_t                         head_tag [NUM_CLASSES];
    seq_t                         nxt_seq  [NUM_CLASSES];
    logic [NUM_CLASSES-1:0]       nonempty;
    logic [NUM_CLASSES-1:0]       reject;
    logic [NUM_CLASSES-1:0]       chg;
    logic [NUM_CLASSES-1:0]       push;
    logic [NUM_CLASSES-1:0]       elig;
    logic [NUM_CLASSES-1:0]       take;
    logic [NUM_CLASSES-1:0]       older [NUM_CLASSES];
    logic [ISSUE_W-1:0]           slot_v;
    logic [ISSUE_W-1:0][CLS_W-1:0] slot_cls;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_pool
        assign push[c] = ins_valid && (ins_class == CLS_W'(c));
        // a head above the squash bound is gone this cycle and may not issue
        assign elig[c] = nonempty[c] && fu_free[c] &&
                         (!squash_valid || (head_seq[c] <= squash_bound));

        issel_pool #(.DEPTH(POOL_DEPTH)) u_pool (
            .clk          (clk),
            .rst_n        (rst_n),
            .push         (push[c]),
            .push_seq     (ins_seq),
            .push_tag     (ins_tag),
            .pop          (take[c]),
            .sq_valid     (squash_valid),
            .sq_bound     (squash_bound),
            .head_seq     (head_seq[c]),
            .head_tag     (head_tag[c]),
            .nonempty     (nonempty[c]),
            .reject       (reject[c]),
            .nxt_head_seq (nxt_seq[c]),
            .head_chg     (chg[c])
        );
    end

    issel_age #(.N(NUM_CLASSES)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_seq (nxt_seq),
        .chg     (chg),
        .older   (older)
    );

    issel_pick #(.N(NUM_CLASSES), .W(ISSUE_W)) u_pick (
        .elig     (elig),
        .older    (older),
        .slot_v   (slot_v),
        .slot_cls (slot_cls),
        .take     (take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= '0;
            iss_class <= '0;
            iss_seq   <= '0;
            iss_tag   <= '0;
            ins_err   <= 1'b0;
        end else begin
            for (int s = 0; s < ISSUE_W; s++) begin
                iss_valid[s] <= slot_v[s];
                iss_class[s] <= slot_cls[s];
                iss_seq[s]   <= head_seq[slot_cls[s]];
                iss_tag[s]   <= head_tag[slot_cls[s]];
            end
            ins_err <= |reject;
        end
    end

    assign has_ready = |nonempty;

endmodule

// File: rtl/issel_chk.sv
module issel_chk #(
    parameter int NUM_CLASSES = 4,
    parameter int ISSUE_W     = 2,
    localparam int CLS_W = $clog2(NUM_CLASSES)
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     ins_valid,
    input logic [NUM_CLASSES-1:0]                   fu_free,
    input logic                                     squash_valid,
    input logic [issel_pkg::SEQ_W-1:0]              squash_bound,
    input logic [ISSUE_W-1:0]                       iss_valid,
    input logic [ISSUE_W-1:0][CLS_W-1:0]            iss_class,
    input logic [ISSUE_W-1:0][issel_pkg::SEQ_W-1:0] iss_seq,
    input logic                                     has_ready,
    input logic                                     ins_err
);

    logic [NUM_CLASSES-1:0]        fu_prev;
    logic                          sq_prev;
    logic [issel_pkg::SEQ_W-1:0]   bound_prev;

    always_ff @(posedge clk) begin
        fu_prev    <= fu_free;
        sq_prev    <= squash_valid;
        bound_prev <= squash_bound;
    end

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        AST_FU_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s] |-> fu_prev[iss_class[s]]); // R5
        AST_SQUASH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[s] && sq_prev) |-> (iss_seq[s] <= bound_prev)); // R6
        AST_ISSUE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s] |-> $past(has_ready)); // R7
    end

    for (genvar s = 1; s < ISSUE_W; s++) begin : g_order
        AST_SLOT_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s] |-> (iss_valid[s-1] && (iss_seq[s-1] < iss_seq[s]) &&
                              (iss_class[s-1] != iss_class[s]))); // R4
    end

    AST_ERR_FROM_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_err |-> $past(ins_valid)); // R8

endmodule

bind issel_top issel_chk #(.NUM_CLASSES(NUM_CLASSES), .ISSUE_W(ISSUE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .fu_free      (fu_free),
    .squash_valid (squash_valid),
    .squash_bound (squash_bound),
    .iss_valid    (iss_valid),
    .iss_class    (iss_class),
    .iss_seq      (iss_seq),
    .has_ready    (has_ready),
    .ins_err      (ins_err)
);

// File: tb/issel_top_tb.sv
module issel_top_tb;

    localparam int NC = 4;
    localparam int IW = 2;
    localparam int DEPTH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic [15:0]       ins_seq = '0;
    logic [1:0]        ins_class = '0;
    logic [7:0]        ins_tag = '0;
    logic [NC-1:0]     fu_free = '0;
    logic              squash_valid = 1'b0;
    logic [15:0]       squash_bound = '0;
    logic [IW-1:0]     iss_valid;
    logic [IW-1:0][1:0]  iss_class;
    logic [IW-1:0][15:0] iss_seq;
    logic [IW-1:0][7:0]  iss_tag;
    logic              has_ready;
    logic              ins_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int mq_seq [NC][$];
    int mq_tag [NC][$];

    always #2 clk = ~clk;

    issel_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .ins_seq      (ins_seq),
        .ins_class    (ins_class),
        .ins_tag      (ins_tag),
        .fu_free      (fu_free),
        .squash_valid (squash_valid),
        .squash_bound (squash_bound),
        .iss_valid    (iss_valid),
        .iss_class    (iss_class),
        .iss_seq      (iss_seq),
        .iss_tag      (iss_tag),
        .has_ready    (has_ready),
        .ins_err      (ins_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock of stimulus, model update and comparison after the edge
    task automatic step(input bit iv, input int s, input int c, input int t,
                        input bit [NC-1:0] fu, input bit sv, input int b, input string req);
        bit taken [NC];
        bit pv [IW];
        int pc [IW];
        int pre_size;
        bit doomed;
        bit exp_err;
        bit exp_ready;
        int k;
        ins_valid = iv; ins_seq = 16'(s); ins_class = 2'(c); ins_tag = 8'(t);
        fu_free = fu; squash_valid = sv; squash_bound = 16'(b);

        for (int x = 0; x < NC; x++) taken[x] = 0;
        for (int sl = 0; sl < IW; sl++) begin
            int best = -1;
            for (int x = 0; x < NC; x++) begin
                if (!taken[x] && fu[x] && mq_seq[x].size() > 0 &&
                    (!sv || mq_seq[x][0] <= b)) begin
                    if (best < 0 || mq_seq[x][0] < mq_seq[best][0]) best = x;
                end
            end
            pv[sl] = (best >= 0);
            pc[sl] = best;
            if (best >= 0) taken[best] = 1;
        end

        pre_size = mq_seq[c].size();
        doomed   = sv && (s > b);
        exp_err  = iv && !doomed && (pre_size == DEPTH);

        for (int sl = 0; sl < IW; sl++) begin
            if (pv[sl]) begin
                checks = checks; // issued values captured before popping
            end
        end
        begin
            int ps [IW];
            int pt [IW];
            for (int sl = 0; sl < IW; sl++) begin
                ps[sl] = pv[sl] ? mq_seq[pc[sl]][0] : 0;
                pt[sl] = pv[sl] ? mq_tag[pc[sl]][0] : 0;
            end
            if (sv) begin
                for (int x = 0; x < NC; x++) begin
                    while (mq_seq[x].size() > 0 && mq_seq[x][$] > b) begin
                        void'(mq_seq[x].pop_back());
                        void'(mq_tag[x].pop_back());
                    end
                end
            end
            for (int sl = 0; sl < IW; sl++) begin
                if (pv[sl]) begin
                    void'(mq_seq[pc[sl]].pop_front());
                    void'(mq_tag[pc[sl]].pop_front());
                end
            end
            if (iv && !doomed && pre_size < DEPTH) begin
                k = 0;
                while (k < mq_seq[c].size() && mq_seq[c][k] < s) k++;
                mq_seq[c].insert(k, s);
                mq_tag[c].insert(k, t);
            end
            exp_ready = 0;
            for (int x = 0; x < NC; x++) if (mq_seq[x].size() > 0) exp_ready = 1;

            @(posedge clk);
            #1;
            for (int sl = 0; sl < IW; sl++) begin
                chk(req, $sformatf("slot%0d valid", sl), int'(iss_valid[sl]), int'(pv[sl]));
                if (pv[sl] && iss_valid[sl]) begin
                    chk(req, $sformatf("slot%0d class", sl), int'(iss_class[sl]), pc[sl]);
                    chk(req, $sformatf("slot%0d seq", sl), int'(iss_seq[sl]), ps[sl]);
                    chk(req, $sformatf("slot%0d tag", sl), int'(iss_tag[sl]), pt[sl]);
                end
            end
            chk("R7", "has_ready", int'(has_ready), int'(exp_ready));
            chk("R8", "ins_err", int'(ins_err), int'(exp_err));
        end
    endtask

    task automatic idle(input bit [NC-1:0] fu, input string req);
        step(0, 0, 0, 0, fu, 0, 0, req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int nseq;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset iss_valid", int'(iss_valid), 0);
        chk("R1", "reset has_ready", int'(has_ready), 0);
        chk("R1", "reset ins_err", int'(ins_err), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "post-reset iss_valid", int'(iss_valid), 0);
        chk("R1", "post-reset has_ready", int'(has_ready), 0);

        // R2 R3: out-of-order arrival into class 1, drained oldest first
        step(1, 30, 1, 130, 4'b0000, 0, 0, "R2");
        step(1, 10, 1, 110, 4'b0000, 0, 0, "R3");
        step(1, 20, 1, 120, 4'b0000, 0, 0, "R3");
        repeat (4) idle(4'b0010, "R3");

        // R4 R10: head re-placement after issue
        step(1, 1, 0, 1, 4'b0000, 0, 0, "R10");
        step(1, 40, 0, 40, 4'b0000, 0, 0, "R10");
        step(1, 5, 2, 5, 4'b0000, 0, 0, "R10");
        step(1, 3, 3, 3, 4'b0000, 0, 0, "R10");
        repeat (3) idle(4'b1111, "R4");

        // R5: oldest class busy, walk continues
        step(1, 50, 0, 50, 4'b0000, 0, 0, "R5");
        step(1, 51, 1, 51, 4'b0000, 0, 0, "R5");
        step(1, 52, 2, 52, 4'b0000, 0, 0, "R5");
        idle(4'b1110, "R5");
        idle(4'b1111, "R5");

        // R9: insert with unit free issues one edge later
        step(1, 55, 3, 55, 4'b1111, 0, 0, "R9");
        idle(4'b1111, "R9");
        idle(4'b1111, "R9");

        // R6: squash overlapping issue and a doomed insert
        step(1, 60, 0, 60, 4'b0000, 0, 0, "R6");
        step(1, 70, 0, 70, 4'b0000, 0, 0, "R6");
        step(1, 65, 1, 65, 4'b0000, 0, 0, "R6");
        step(1, 75, 1, 75, 4'b0000, 0, 0, "R6");
        step(1, 80, 2, 80, 4'b1111, 1, 66, "R6");
        repeat (2) idle(4'b1111, "R6");

        // R8: overfill class 3
        for (int i = 0; i < DEPTH + 1; i++)
            step(1, 100 + i, 3, i, 4'b0000, 0, 0, "R8");
        step(1, 200, 3, 9, 4'b1000, 0, 0, "R8");
        repeat (10) idle(4'b1111, "R8");

        // random mix of all functions
        nseq = 300;
        for (int n = 0; n < 600; n++) begin
            bit sv;
            int b;
            nseq = nseq + int'($urandom_range(1, 3));
            sv = ($urandom_range(0, 19) == 0);
            b  = nseq - int'($urandom_range(1, 12));
            step($urandom_range(0, 3) != 0, nseq, int'($urandom_range(0, NC - 1)),
                 nseq & 255, 4'($urandom_range(0, 15)), sv, b, "R4");
        end
        repeat (12) idle(4'b1111, "R4");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule